// File: doc/BRIEF.md
# Multi-domain reset sequencer

This block generates the resets for three domains of a chip: system, peripheral and backup. It accepts four kinds of reset request: power-on, an external reset pin, a one-cycle software request and a watchdog timeout. Each source is mapped to a set of target domains and can be masked. Together, the accepted requests decide which domains take part in a reset sequence.

The domains are always asserted and released in a fixed order. The system domain is asserted first, then the peripheral domain. The system domain is released before the peripheral domain, and the backup domain is pulsed last. Domains outside the target set skip their steps. Hold and settle lengths come from a small register bank, which also sets the routing, the masks and a minimum pulse width. Sticky cause bits record every accepted source, and software clears them by writing ones.

A request that arrives during a running sequence adds its domains to the target set. If its first step lies at or before the current step, the sequence restarts at that step. Power-on holds all three outputs asserted from reset and then runs the full sequence with the default delays.

Top module: `rst_seq_top`

## Requirements
- R1: While `por_n` is low, all three reset outputs read 1 and `cause_o` reads 4'b0001. After release, the full sequence runs with the default delays: system falls after 2H cycles, peripheral after 2H+S and backup after 3H+2S, counted from the first clock edge after release.
- R2: For a full target set, triggered at edge E0, the order is as follows. System rises at E0 and peripheral at E0+H. System falls at E0+2H and peripheral at E0+2H+S. Backup rises at E0+2H+2S and falls at E0+3H+2S. Steps of domains outside the target set are skipped and the later steps move up.
- R3: The hold length is H = max(hold, minimum width, 1), so a hold of 0 acts as 1. The settle length is S = max(settle, 1). Hold is at address 1, settle at address 2 and minimum width at address 3.
- R4: The external-pin route is the field ctrl[1:0] at address 0. The value 1 selects the system domain only; every other value selects all three domains.
- R5: The watchdog route is ctrl[3:2]. The value 1 selects the system domain, 2 selects the peripheral domain, and 0 or 3 select all three domains.
- R6: The software route is ctrl[5:4]. The value 1 selects the system domain, 2 the peripheral domain, 3 both of them, and 0 all three domains.
- R7: The mask bits ctrl[6], ctrl[7] and ctrl[8] belong to the external pin, the watchdog and the software request. A set mask bit makes its source cause no reset and set no cause bit.
- R8: Cause bits are bit 0 power-on, bit 1 external, bit 2 watchdog and bit 3 software. They stay set until software writes a 1 to that bit position at address 4, and a zero bit leaves the cause bit alone.
- R9: Suppose a request arrives while a sequence runs and its first step lies at or before the current step. The sequence then restarts there with the merged target set, and the cause is still recorded.
- R10: The external and watchdog pins pass two synchronizer flops and a rising-edge detector. A pin set before edge P starts the sequence at edge P+2. A pin held high triggers only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_i | input | 1 | External reset pin, active high, asynchronous |
| wdt_rst_i | input | 1 | Watchdog timeout, active high, asynchronous |
| sw_rst_i | input | 1 | Software reset request, one-cycle pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration register address |
| cfg_wdata | input | DATA_W | Configuration write data |
| rst_sys_o | output | 1 | System domain reset, active high |
| rst_per_o | output | 1 | Peripheral domain reset, active high |
| rst_bak_o | output | 1 | Backup domain reset, active high |
| cause_o | output | 4 | Sticky reset-cause bits |

## Verification
The bench builds the block with a 4-bit delay counter, a default hold of 3, a default settle of 2 and a minimum width of 0. With these values every hold, settle and minimum-width combination, including the zero cases, runs in a few tens of cycles. This allows a sweep over all three settings in which the first-assertion cycle and the asserted length of each output are compared with closed-form values in H and S. Every routing code of each source, each mask, the partial clearing of cause bits and a restart in the middle of a sequence are checked cycle by cycle as well.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    localparam int DOM_SYS = 0;
    localparam int DOM_PER = 1;
    localparam int DOM_BAK = 2;

    localparam int CS_POR = 0;
    localparam int CS_EXT = 1;
    localparam int CS_WDT = 2;
    localparam int CS_SW  = 3;

    // Encoding order is the step order; restart compares against it.
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_SYS_ON  = 3'd1,
        PH_PER_ON  = 3'd2,
        PH_SYS_OFF = 3'd3,
        PH_PER_OFF = 3'd4,
        PH_BAK_ON  = 3'd5
    } phase_e;

    typedef struct packed {
        logic [2:0] mask;      // [2] software, [1] watchdog, [0] pin
        logic [1:0] sw_mode;
        logic [1:0] wdt_mode;
        logic [1:0] ext_mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic phase_e first_phase(input logic [2:0] t);
        if (t[DOM_SYS])      return PH_SYS_ON;
        else if (t[DOM_PER]) return PH_PER_ON;
        else if (t[DOM_BAK]) return PH_BAK_ON;
        else                 return PH_IDLE;
    endfunction

    function automatic phase_e next_phase(input phase_e cur, input logic [2:0] t);
        case (cur)
            PH_SYS_ON:  return t[DOM_PER] ? PH_PER_ON : PH_SYS_OFF;
            PH_PER_ON:  return t[DOM_SYS] ? PH_SYS_OFF : PH_PER_OFF;
            PH_SYS_OFF: return t[DOM_PER] ? PH_PER_OFF : (t[DOM_BAK] ? PH_BAK_ON : PH_IDLE);
            PH_PER_OFF: return t[DOM_BAK] ? PH_BAK_ON : PH_IDLE;
            default:    return PH_IDLE;
        endcase
    endfunction

    function automatic logic is_hold_phase(input phase_e p);
        return (p == PH_SYS_ON) || (p == PH_PER_ON) || (p == PH_BAK_ON);
    endfunction

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              last;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.sh   = {q.sh[STAGES-2:0], pin_i};
        d.last = q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rise_o = q.sh[STAGES-1] & ~q.last;

endmodule

// File: rtl/rst_seq_cfg.sv
module rst_seq_cfg
    import rst_seq_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int DATA_W     = 9,
    parameter int ADDR_W     = 3,
    parameter int DEF_HOLD   = 4,
    parameter int DEF_SETTLE = 2,
    parameter int DEF_MINPW  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [3:0]        cause_set_i,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  hold_o,
    output logic [CNT_W-1:0]  settle_o,
    output logic [CNT_W-1:0]  minpw_o,
    output logic [3:0]        cause_o
);

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_HOLD   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_SETTLE = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_MINPW  = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(4);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] hold;
        logic [CNT_W-1:0] settle;
        logic [CNT_W-1:0] minpw;
        logic [3:0]       cause;
    } cfg_t;

    cfg_t       q, d;
    logic [3:0] clr;

    always_comb begin
        d   = q;
        clr = '0;
        if (we_i) begin
            case (addr_i)
                A_CTRL:   d.ctrl   = ctrl_t'(wdata_i[CTRL_W-1:0]);
                A_HOLD:   d.hold   = wdata_i[CNT_W-1:0];
                A_SETTLE: d.settle = wdata_i[CNT_W-1:0];
                A_MINPW:  d.minpw  = wdata_i[CNT_W-1:0];
                A_CLEAR:  clr      = wdata_i[3:0];
                default:  ;
            endcase
        end
        // a new cause wins over a clear in the same cycle
        d.cause = (q.cause & ~clr) | cause_set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ctrl   <= '0;
            q.hold   <= CNT_W'(DEF_HOLD);
            q.settle <= CNT_W'(DEF_SETTLE);
            q.minpw  <= CNT_W'(DEF_MINPW);
            q.cause  <= 4'b0001;
        end else begin
            q <= d;
        end
    end

    assign ctrl_o   = q.ctrl;
    assign hold_o   = q.hold;
    assign settle_o = q.settle;
    assign minpw_o  = q.minpw;
    assign cause_o  = q.cause;

endmodule

// File: rtl/rst_seq_route.sv
module rst_seq_route
    import rst_seq_pkg::*;
(
    input  ctrl_t      ctrl_i,
    input  logic       ext_rise_i,
    input  logic       wdt_rise_i,
    input  logic       sw_req_i,
    output logic [3:0] accept_o,
    output logic [2:0] req_tgt_o
);

    logic       ext_ok, wdt_ok, sw_ok;
    logic [2:0] ext_t, wdt_t, sw_t;

    always_comb begin
        ext_ok = ext_rise_i & ~ctrl_i.mask[0];
        wdt_ok = wdt_rise_i & ~ctrl_i.mask[1];
        sw_ok  = sw_req_i   & ~ctrl_i.mask[2];

        ext_t = (ctrl_i.ext_mode == 2'd1) ? 3'b001 : 3'b111;

        case (ctrl_i.wdt_mode)
            2'd1:    wdt_t = 3'b001;
            2'd2:    wdt_t = 3'b010;
            default: wdt_t = 3'b111;
        endcase

        case (ctrl_i.sw_mode)
            2'd1:    sw_t = 3'b001;
            2'd2:    sw_t = 3'b010;
            2'd3:    sw_t = 3'b011;
            default: sw_t = 3'b111;
        endcase

        req_tgt_o = ({3{ext_ok}} & ext_t) | ({3{wdt_ok}} & wdt_t) | ({3{sw_ok}} & sw_t);

        accept_o         = '0;
        accept_o[CS_EXT] = ext_ok;
        accept_o[CS_WDT] = wdt_ok;
        accept_o[CS_SW]  = sw_ok;
    end

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int DEF_HOLD  = 4,
    parameter int DEF_MINPW = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       req_tgt_i,
    input  logic [CNT_W-1:0] hold_i,
    input  logic [CNT_W-1:0] settle_i,
    input  logic [CNT_W-1:0] minpw_i,
    output logic [2:0]       rst_o,
    output phase_e           phase_o
);

    localparam int POR_HOLD_RAW = (DEF_HOLD > DEF_MINPW) ? DEF_HOLD : DEF_MINPW;
    localparam int POR_HOLD     = (POR_HOLD_RAW < 1) ? 1 : POR_HOLD_RAW;

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       tgt;
        logic [2:0]       rst;
    } seq_t;

    seq_t             q, d;
    logic [CNT_W-1:0] hold_raw, hold_len, settle_len;
    logic [2:0]       tgt_m;
    phase_e           fp, nxt;
    logic             restart, step;

    always_comb begin
        hold_raw   = (hold_i > minpw_i) ? hold_i : minpw_i;
        hold_len   = (hold_raw == '0) ? CNT_W'(1) : hold_raw;
        settle_len = (settle_i == '0) ? CNT_W'(1) : settle_i;

        tgt_m   = q.tgt | req_tgt_i;
        fp      = first_phase(req_tgt_i);
        restart = (req_tgt_i != '0) && ((q.phase == PH_IDLE) || (fp <= q.phase));
        step    = restart || ((q.phase != PH_IDLE) && (q.cnt == '0));
        nxt     = restart ? fp : next_phase(q.phase, tgt_m);

        d     = q;
        d.tgt = tgt_m;
        if (step) begin
            d.phase = nxt;
            if (nxt == PH_IDLE)        d.cnt = '0;
            else if (is_hold_phase(nxt)) d.cnt = hold_len - CNT_W'(1);
            else                       d.cnt = settle_len - CNT_W'(1);
            case (nxt)
                PH_SYS_ON:  d.rst[DOM_SYS] = 1'b1;
                PH_PER_ON:  d.rst[DOM_PER] = 1'b1;
                PH_SYS_OFF: d.rst[DOM_SYS] = 1'b0;
                PH_PER_OFF: d.rst[DOM_PER] = 1'b0;
                PH_BAK_ON:  d.rst[DOM_BAK] = 1'b1;
                default: begin
                    d.rst[DOM_BAK] = 1'b0;
                    d.tgt          = '0;
                end
            endcase
        end else if (q.phase != PH_IDLE) begin
            d.cnt = q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase <= PH_SYS_ON;
            q.cnt   <= CNT_W'(POR_HOLD - 1);
            q.tgt   <= 3'b111;
            q.rst   <= 3'b111;
        end else begin
            q <= d;
        end
    end

    assign rst_o   = q.rst;
    assign phase_o = q.phase;

endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
    import rst_seq_pkg::*;
#(
    parameter  int CNT_W       = 8,
    parameter  int DEF_HOLD    = 4,
    parameter  int DEF_SETTLE  = 2,
    parameter  int DEF_MINPW   = 0,
    parameter  int SYNC_STAGES = 2,
    parameter  int ADDR_W      = 3,
    localparam int DATA_W      = (CNT_W > CTRL_W) ? CNT_W : CTRL_W
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst_i,
    input  logic              wdt_rst_i,
    input  logic              sw_rst_i,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              rst_sys_o,
    output logic              rst_per_o,
    output logic              rst_bak_o,
    output logic [3:0]        cause_o
);

    localparam int N_PINS = 2;

    logic [N_PINS-1:0] pin_raw, pin_rise;
    ctrl_t             ctrl;
    logic [CNT_W-1:0]  hold, settle, minpw;
    logic [3:0]        accept;
    logic [2:0]        req_tgt, rst_vec;
    phase_e            phase;

    assign pin_raw = {wdt_rst_i, ext_rst_i};

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        rst_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (por_n),
            .pin_i  (pin_raw[g]),
            .rise_o (pin_rise[g])
        );
    end

    rst_seq_cfg #(
        .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .DEF_HOLD(DEF_HOLD), .DEF_SETTLE(DEF_SETTLE), .DEF_MINPW(DEF_MINPW)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (por_n),
        .we_i        (cfg_we),
        .addr_i      (cfg_addr),
        .wdata_i     (cfg_wdata),
        .cause_set_i (accept),
        .ctrl_o      (ctrl),
        .hold_o      (hold),
        .settle_o    (settle),
        .minpw_o     (minpw),
        .cause_o     (cause_o)
    );

    rst_seq_route u_route (
        .ctrl_i     (ctrl),
        .ext_rise_i (pin_rise[0]),
        .wdt_rise_i (pin_rise[1]),
        .sw_req_i   (sw_rst_i),
        .accept_o   (accept),
        .req_tgt_o  (req_tgt)
    );

    rst_seq_fsm #(
        .CNT_W(CNT_W), .DEF_HOLD(DEF_HOLD), .DEF_MINPW(DEF_MINPW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (por_n),
        .req_tgt_i (req_tgt),
        .hold_i    (hold),
        .settle_i  (settle),
        .minpw_i   (minpw),
        .rst_o     (rst_vec),
        .phase_o   (phase)
    );

    assign rst_sys_o = rst_vec[DOM_SYS];
    assign rst_per_o = rst_vec[DOM_PER];
    assign rst_bak_o = rst_vec[DOM_BAK];

endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk
    import rst_seq_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   rst_sys,
    input logic   rst_per,
    input logic   rst_bak,
    input logic   sw_req,
    input logic   sw_masked,
    input logic   cause_sw,
    input phase_e phase
);

    // R2: backup is pulsed only once the other two domains are released
    p_bak_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_bak) |-> (!rst_sys && !rst_per));

    // R2: peripheral release never precedes system release
    p_per_after_sys_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_per) |-> !rst_sys);

    // R2: an idle sequencer holds no domain in reset
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> (!rst_sys && !rst_per && !rst_bak));

    // R7: the software cause bit only rises after an unmasked request
    p_sw_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cause_sw) |-> $past(sw_req && !sw_masked));

    // R9: a new request always pulls an idle sequencer out of idle
    p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_IDLE) && sw_req && !sw_masked) |=> (phase != PH_IDLE));

endmodule

bind rst_seq_top rst_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (por_n),
    .rst_sys   (rst_sys_o),
    .rst_per   (rst_per_o),
    .rst_bak   (rst_bak_o),
    .sw_req    (sw_rst_i),
    .sw_masked (ctrl.mask[2]),
    .cause_sw  (cause_o[3]),
    .phase     (phase)
);

// File: tb/tb_rst_seq_top.sv
module tb_rst_seq_top;

    localparam int CNT_W  = 4;
    localparam int DEF_H  = 3;
    localparam int DEF_S  = 2;
    localparam int DATA_W = 9;

    logic              clk = 1'b0;
    logic              por_n = 1'b0;
    logic              ext_rst_i = 1'b0;
    logic              wdt_rst_i = 1'b0;
    logic              sw_rst_i = 1'b0;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_addr = '0;
    logic [DATA_W-1:0] cfg_wdata = '0;
    logic              rst_sys_o, rst_per_o, rst_bak_o;
    logic [3:0]        cause_o;

    int checks = 0;
    int failures = 0;
    int fs, cs, fp, cp, fb, cb;

    always #5 clk = ~clk;

    rst_seq_top #(
        .CNT_W(CNT_W), .DEF_HOLD(DEF_H), .DEF_SETTLE(DEF_S), .DEF_MINPW(0),
        .SYNC_STAGES(2), .ADDR_W(3)
    ) dut (
        .clk(clk), .por_n(por_n), .ext_rst_i(ext_rst_i), .wdt_rst_i(wdt_rst_i),
        .sw_rst_i(sw_rst_i), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rst_sys_o(rst_sys_o), .rst_per_o(rst_per_o), .rst_bak_o(rst_bak_o), .cause_o(cause_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int v);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = DATA_W'(v);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic trig_sw();
        sw_rst_i = 1'b1;
        @(negedge clk);
        sw_rst_i = 1'b0;
    endtask

    task automatic trig_pin(input bit use_wdt);
        if (use_wdt) wdt_rst_i = 1'b1; else ext_rst_i = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic drop_pins();
        ext_rst_i = 1'b0; wdt_rst_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // sample n = 0 is the negedge after the triggering edge
    task automatic measure(input int win, input int inj);
        fs = -1; fp = -1; fb = -1; cs = 0; cp = 0; cb = 0;
        for (int n = 0; n < win; n++) begin
            if (rst_sys_o) begin if (fs < 0) fs = n; cs++; end
            if (rst_per_o) begin if (fp < 0) fp = n; cp++; end
            if (rst_bak_o) begin if (fb < 0) fb = n; cb++; end
            if (n == inj) wdt_rst_i = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic expect_seq(input string req, input logic [2:0] t, input int h, input int s);
        int es, ecs, ep, ecp, eb, ecb;
        es  = t[0] ? 0 : -1;
        ecs = t[0] ? (t[1] ? 2*h : h) : 0;
        ep  = t[1] ? (t[0] ? h : 0) : -1;
        ecp = t[1] ? (t[0] ? h + s : h) : 0;
        eb  = t[2] ? ((t[0] && t[1]) ? 2*h + 2*s : ((t[0] || t[1]) ? h + s : 0)) : -1;
        ecb = t[2] ? h : 0;
        chk(req, "sys_first", fs, es);
        chk(req, "sys_len", cs, ecs);
        chk(req, "per_first", fp, ep);
        chk(req, "per_len", cp, ecp);
        chk(req, "bak_first", fb, eb);
        chk(req, "bak_len", cb, ecb);
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [2:0] t;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "sys_in_reset", int'(rst_sys_o), 1);
        chk("R1", "per_in_reset", int'(rst_per_o), 1);
        chk("R1", "bak_in_reset", int'(rst_bak_o), 1);
        chk("R1", "cause", int'(cause_o), 1);
        por_n = 1'b1;
        measure(3*DEF_H + 2*DEF_S + 4, -1);
        chk("R1", "por_sys_len", cs, 2*DEF_H);
        chk("R1", "por_per_len", cp, 2*DEF_H + DEF_S);
        chk("R1", "por_bak_len", cb, 3*DEF_H + 2*DEF_S);
        wr(3'd4, 'hF);
        chk("R8", "cause_cleared", int'(cause_o), 0);

        // R2 R3: sweep hold, minimum width and settle with a full target set
        for (int hv = 0; hv < 4; hv++) begin
            for (int mi = 0; mi < 3; mi++) begin
                for (int si = 0; si < 3; si++) begin
                    int m, s, eh, es2;
                    m = (mi == 0) ? 0 : ((mi == 1) ? 2 : 5);
                    s = (si == 0) ? 0 : ((si == 1) ? 1 : 3);
                    wr(3'd1, hv); wr(3'd3, m); wr(3'd2, s);
                    eh  = imax(imax(hv, m), 1);
                    es2 = imax(s, 1);
                    trig_sw();
                    measure(3*eh + 2*es2 + 4, -1);
                    expect_seq("R2 R3", 3'b111, eh, es2);
                end
            end
        end
        chk("R8", "cause_sw_sticky", int'(cause_o), 4'b1000);

        wr(3'd1, 2); wr(3'd3, 0); wr(3'd2, 1);

        // R6 software routing
        for (int md = 0; md < 4; md++) begin
            wr(3'd0, md << 4);
            t = (md == 1) ? 3'b001 : (md == 2) ? 3'b010 : (md == 3) ? 3'b011 : 3'b111;
            trig_sw();
            measure(14, -1);
            expect_seq("R6", t, 2, 1);
        end

        // R5 watchdog routing
        for (int md = 0; md < 4; md++) begin
            wr(3'd0, md << 2);
            t = (md == 1) ? 3'b001 : (md == 2) ? 3'b010 : 3'b111;
            trig_pin(1'b1);
            measure(14, -1);
            expect_seq("R5", t, 2, 1);
            drop_pins();
        end
        chk("R8", "cause_sw_wdt", int'(cause_o), 4'b1100);

        // R4 R10 external pin routing, latency and single trigger on a held level
        for (int md = 0; md < 4; md++) begin
            wr(3'd0, md);
            t = (md == 1) ? 3'b001 : 3'b111;
            trig_pin(1'b0);
            measure(14, -1);
            expect_seq("R4 R10", t, 2, 1);
            measure(10, -1);
            chk("R10", "held_pin_sys", cs, 0);
            chk("R10", "held_pin_bak", cb, 0);
            drop_pins();
        end
        chk("R8", "cause_all_three", int'(cause_o), 4'b1110);
        wr(3'd4, 4'b0010);
        chk("R8", "partial_clear", int'(cause_o), 4'b1100);
        wr(3'd4, 4'b1111);
        chk("R8", "full_clear", int'(cause_o), 0);

        // R7 masks: every source masked in turn
        for (int src = 0; src < 3; src++) begin
            wr(3'd0, 1 << (6 + src));
            if (src == 2) trig_sw(); else trig_pin(src == 1);
            measure(12, -1);
            chk("R7", "masked_sys", cs, 0);
            chk("R7", "masked_per", cp, 0);
            chk("R7", "masked_bak", cb, 0);
            drop_pins();
            chk("R7", "masked_cause", int'(cause_o), 0);
        end

        // R9 watchdog (peripheral) arrives while system release settles
        wr(3'd0, 2 << 2);
        wr(3'd1, 2); wr(3'd3, 0); wr(3'd2, 2);
        trig_sw();
        measure(18, 2);
        chk("R9", "sys_first", fs, 0);
        chk("R9", "sys_len", cs, 4);
        chk("R9", "per_first", fp, 2);
        chk("R9", "per_len", cp, 7);
        chk("R9", "bak_first", fb, 11);
        chk("R9", "bak_len", cb, 2);
        drop_pins();
        chk("R9", "cause_merged", int'(cause_o), 4'b1100);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule